// File: doc/BRIEF.md
# Multiplexer-Built Configurable ALU

This block is an N-bit combinational datapath made of identical bit slices. Each slice has two small 4-to-1 selectors. Both selectors are indexed by the pair formed from the slice's A bit and its conditioned B bit. The conditioned B bit is B, inverted when the subtract control is set.

The first selector reads a shared 4-bit function code, so every slice can produce any two-input Boolean function of its operand pair. The second selector builds a pass-through carry chain:

- When the operand pair differs, it forwards the carry from below.
- When both bits are one, it outputs an external generate line.
- When both bits are zero, it outputs an external kill line.

Each result bit is the first selector's output XORed with the carry arriving at that slice. With these controls the same wiring performs any bitwise logic function, addition, two's-complement subtraction, or a borrow-style subtraction that also acts as a magnitude compare.

Top module: `alu_mux_alu`

## Requirements
- R1: With gen_i=0, kill_i=0 and cin_i=0, every internal carry is zero. res_o[i] then equals func_i[{a_i[i], b_i[i]^sub_i}], where the 2-bit index has A as its upper bit, and cout_o is 0.
- R2: With func_i=4'b0110, sub_i=0, gen_i=1 and kill_i=0, {cout_o, res_o} equals a_i + b_i + cin_i.
- R3: With func_i=4'b0110, sub_i=1, cin_i=1, gen_i=1 and kill_i=0, res_o equals a_i - b_i modulo 2^W, and cout_o is 1 exactly when a_i >= b_i (unsigned).
- R4: In any slice whose A bit differs from its conditioned B bit, the carry leaving the slice equals the carry entering it.
- R5: In any slice whose A bit and conditioned B bit are both 1, the carry leaving the slice equals gen_i.
- R6: In any slice whose A bit and conditioned B bit are both 0, the carry leaving the slice equals kill_i.
- R7: Every result bit equals the function-code lookup for that slice XOR the carry entering the slice. The carry entering slice 0 is cin_i, and cout_o is the carry leaving the top slice.
- R8: The default data width W is 8 bits.
- R9: With func_i=4'b0110, sub_i=1, gen_i=0 and kill_i=1, cin_i acts as a borrow-in. In this mode res_o equals the bitwise inverse of (a_i - b_i - cin_i), and cout_o is 1 exactly when a_i < b_i + cin_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Operand A |
| b_i | input | W | Operand B, before the subtract conditioning |
| func_i | input | 4 | Truth table of the per-bit logic function, indexed by {A, conditioned B} |
| sub_i | input | 1 | Inverts every B bit before both selectors |
| gen_i | input | 1 | Carry value produced by slices where both bits are 1 |
| kill_i | input | 1 | Carry value produced by slices where both bits are 0 |
| cin_i | input | 1 | Carry into the least significant slice |
| res_o | output | W | Result word |
| cout_o | output | 1 | Carry leaving the most significant slice |

## Verification
The hardest cases to reach from the ports are the ones where one control line must drive a long run of the chain. Examples are a carry that travels from cin_i through every slice, and a kill or generate value that reaches the top while all lower slices forward it. Random operands almost never produce these.

The stimulus therefore uses complementary patterns such as 0xAA against 0x55, which make every slice propagate. It also uses all-ones and all-zero operand pairs, which put every slice into generate or kill. The logic function code is held at zero or XOR in these tests, so the result word exposes the carry entering each slice bit by bit.

The borrow mode is reached by raising kill_i with gen_i low. It is exercised with equal operands and with operands that differ by one, which sit on both sides of the compare boundary.

// File: rtl/alu_mux_pkg.sv
package alu_mux_pkg;

  localparam int unsigned SEL_W = 2;
  localparam int unsigned TBL_W = 1 << SEL_W;

  // Truth-table lookup: the table bit is picked by {hi, lo}.
  function automatic logic tbl_pick(input logic [TBL_W-1:0] tbl,
                                    input logic hi, input logic lo);
    return tbl[{hi, lo}];
  endfunction

  // Data word for the carry selector, in index order 11,10,01,00.
  function automatic logic [TBL_W-1:0] carry_tbl(input logic gen,
                                                 input logic fwd,
                                                 input logic kill);
    return {gen, fwd, fwd, kill};
  endfunction

endpackage

// File: rtl/alu_mux_sel4.sv
module alu_mux_sel4
  import alu_mux_pkg::*;
(
  input  logic [TBL_W-1:0] data_i,
  input  logic             hi_i,
  input  logic             lo_i,
  output logic             y_o
);
  always_comb y_o = tbl_pick(data_i, hi_i, lo_i);
endmodule

// File: rtl/alu_mux_slice.sv
module alu_mux_slice
  import alu_mux_pkg::*;
(
  input  logic             a_i,
  input  logic             b_i,
  input  logic             sub_i,
  input  logic [TBL_W-1:0] func_i,
  input  logic             gen_i,
  input  logic             kill_i,
  input  logic             cin_i,
  output logic             bx_o,
  output logic             lut_o,
  output logic             res_o,
  output logic             cout_o
);
  logic [TBL_W-1:0] cdata;

  always_comb begin
    bx_o  = b_i ^ sub_i;
    cdata = carry_tbl(gen_i, cin_i, kill_i);
  end

  alu_mux_sel4 u_func (
    .data_i(func_i),
    .hi_i  (a_i),
    .lo_i  (bx_o),
    .y_o   (lut_o)
  );

  alu_mux_sel4 u_carry (
    .data_i(cdata),
    .hi_i  (a_i),
    .lo_i  (bx_o),
    .y_o   (cout_o)
  );

  always_comb res_o = lut_o ^ cin_i;
endmodule

// File: rtl/alu_mux_alu.sv
module alu_mux_alu
  import alu_mux_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [TBL_W-1:0] func_i,
  input  logic             sub_i,
  input  logic             gen_i,
  input  logic             kill_i,
  input  logic             cin_i,
  output logic [W-1:0]     res_o,
  output logic             cout_o
);
  localparam int unsigned CW = W + 1;

  // Chain taps, brought out by name for the checker.
  logic [CW-1:0] carry_w;
  logic [W-1:0]  lut_w;
  logic [W-1:0]  bx_w;

  assign carry_w[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_slice
    alu_mux_slice u_slice (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .sub_i (sub_i),
      .func_i(func_i),
      .gen_i (gen_i),
      .kill_i(kill_i),
      .cin_i (carry_w[i]),
      .bx_o  (bx_w[i]),
      .lut_o (lut_w[i]),
      .res_o (res_o[i]),
      .cout_o(carry_w[i+1])
    );
  end

  assign cout_o = carry_w[W];
endmodule

// File: rtl/alu_mux_alu_chk.sv
module alu_mux_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [3:0]   func_i,
  input logic         sub_i,
  input logic         gen_i,
  input logic         kill_i,
  input logic         cin_i,
  input logic [W-1:0] res_o,
  input logic         cout_o,
  input logic [W:0]   carry_w,
  input logic [W-1:0] lut_w
);
  always_comb begin
    for (int i = 0; i < W; i++) begin
      logic bc;
      bc = b_i[i] ^ sub_i;
      if (a_i[i] != bc)
        a_r4_propagate: assert (carry_w[i+1] == carry_w[i]);
      if (a_i[i] && bc)
        a_r5_generate: assert (carry_w[i+1] == gen_i);
      if (!a_i[i] && !bc)
        a_r6_kill: assert (carry_w[i+1] == kill_i);
      a_r7_result_bit: assert (res_o[i] == (func_i[{a_i[i], bc}] ^ carry_w[i]));
    end
    a_r7_chain_ends: assert (carry_w[0] == cin_i && cout_o == carry_w[W]);
    if (!gen_i && !kill_i && !cin_i)
      a_r1_chain_quiet: assert (carry_w == '0 && res_o == lut_w);
  end
endmodule

bind alu_mux_alu alu_mux_alu_chk #(.W(W)) u_chk (
  .a_i(a_i), .b_i(b_i), .func_i(func_i), .sub_i(sub_i), .gen_i(gen_i),
  .kill_i(kill_i), .cin_i(cin_i), .res_o(res_o), .cout_o(cout_o),
  .carry_w(carry_w), .lut_w(lut_w)
);

// File: tb/tb_alu_mux_alu.sv
module tb_alu_mux_alu;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [3:0]   func;
  logic         sub, gen, kill, cin, cout;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [W:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  alu_mux_alu dut (
    .a_i(a), .b_i(b), .func_i(func), .sub_i(sub), .gen_i(gen),
    .kill_i(kill), .cin_i(cin), .res_o(res), .cout_o(cout)
  );

  // Driver: applies the operands and controls on the falling edge and
  // queues the expected {cout, res}.
  task automatic drive(input logic [W-1:0] ta, input logic [W-1:0] tb_,
                       input logic [3:0] tf, input logic ts, input logic tg,
                       input logic tk, input logic tc, input logic [W:0] e,
                       input string tag);
    item_t it;
    @(negedge clk);
    a = ta; b = tb_; func = tf; sub = ts; gen = tg; kill = tk; cin = tc;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares on the rising edge, half a period after the drive.
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if ({cout, res} !== it.exp) begin
        errors++;
        $display("FAIL %s: got cout=%b res=%h, expected cout=%b res=%h",
                 it.tag, cout, res, it.exp[W], it.exp[W-1:0]);
      end
    end
  end

  // Reference for the pure logic mode: walk the bits and read the table.
  function automatic logic [W:0] ref_logic(logic [W-1:0] x, logic [W-1:0] y,
                                           logic [3:0] f, logic s);
    logic [W:0] r = '0;
    for (int k = 0; k < W; k++) begin
      int idx = (x[k] ? 2 : 0) + ((y[k] ^ s) ? 1 : 0);
      r[k] = f[idx];
    end
    return r;
  endfunction

  function automatic logic [W:0] ref_borrow(logic [W-1:0] x, logic [W-1:0] y,
                                            logic bi);
    logic [W-1:0] d = x - y - W'(bi);
    logic lt = (int'(x) < int'(y) + int'(bi));
    return {lt, ~d};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    a = '0; b = '0; func = '0; sub = 0; gen = 0; kill = 0; cin = 0;
    repeat (2) @(posedge clk);

    drive('0, '0, 4'h0, 0, 0, 0, 0, '0, "R1 reset-state zero");

    // R8: width of the result port.
    checks++;
    if ($bits(res) != 8) begin
      errors++;
      $display("FAIL R8: got width %0d, expected 8", $bits(res));
    end

    // R1: every function code, plain and with B inverted.
    for (int f = 0; f < 16; f++) begin
      for (int n = 0; n < 3; n++) begin
        logic [W-1:0] ra = W'($urandom);
        logic [W-1:0] rb = W'($urandom);
        logic rs = n[0];
        drive(ra, rb, 4'(f), rs, 0, 0, 0, ref_logic(ra, rb, 4'(f), rs), "R1 logic");
      end
    end

    // R4/R7: all slices propagate; the carry from cin reaches the top.
    drive(8'hAA, 8'h55, 4'h0, 0, 0, 0, 1, 9'h1FF, "R4 full propagate");
    drive(8'hAA, 8'h55, 4'h6, 0, 0, 0, 1, 9'h100, "R7 xor with carry");
    drive(8'hAA, 8'hAA, 4'h0, 1, 0, 0, 1, 9'h1FF, "R4 propagate via sub");

    // R5/R6: every slice generates or kills.
    drive(8'hFF, 8'hFF, 4'h0, 0, 1, 0, 0, 9'h1FE, "R5 generate high");
    drive(8'hFF, 8'hFF, 4'h0, 0, 0, 1, 1, 9'h001, "R5 generate low");
    drive(8'h00, 8'h00, 4'h0, 0, 0, 1, 0, 9'h1FE, "R6 kill high");
    drive(8'h00, 8'hFF, 4'h0, 1, 1, 0, 1, 9'h001, "R6 kill low");

    // R2: addition, corners and random.
    drive(8'hFF, 8'h01, 4'h6, 0, 1, 0, 0, 9'h100, "R2 add wrap");
    drive(8'hFF, 8'hFF, 4'h6, 0, 1, 0, 1, 9'h1FF, "R2 add max");
    drive(8'h00, 8'h00, 4'h6, 0, 1, 0, 0, 9'h000, "R2 add zero");
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] ra = W'($urandom);
      logic [W-1:0] rb = W'($urandom);
      logic rc = 1'($urandom);
      drive(ra, rb, 4'h6, 0, 1, 0, rc, {1'b0, ra} + {1'b0, rb} + 9'(rc), "R2 add");
    end

    // R3: two's-complement subtraction.
    drive(8'h5A, 8'h5A, 4'h6, 1, 1, 0, 1, 9'h100, "R3 sub equal");
    drive(8'h00, 8'h01, 4'h6, 1, 1, 0, 1, 9'h0FF, "R3 sub under");
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] ra = W'($urandom);
      logic [W-1:0] rb = W'($urandom);
      drive(ra, rb, 4'h6, 1, 1, 0, 1, {ra >= rb, ra - rb}, "R3 sub");
    end

    // R9: borrow sense / magnitude compare.
    drive(8'h33, 8'h33, 4'h6, 1, 0, 1, 0, ref_borrow(8'h33, 8'h33, 0), "R9 equal");
    drive(8'h33, 8'h33, 4'h6, 1, 0, 1, 1, ref_borrow(8'h33, 8'h33, 1), "R9 equal borrow-in");
    drive(8'h34, 8'h33, 4'h6, 1, 0, 1, 0, ref_borrow(8'h34, 8'h33, 0), "R9 greater");
    drive(8'h32, 8'h33, 4'h6, 1, 0, 1, 0, ref_borrow(8'h32, 8'h33, 0), "R9 less");
    for (int n = 0; n < 30; n++) begin
      logic [W-1:0] ra = W'($urandom);
      logic [W-1:0] rb = W'($urandom);
      logic rc = 1'($urandom);
      drive(ra, rb, 4'h6, 1, 0, 1, rc, ref_borrow(ra, rb, rc), "R9 borrow");
    end

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule